// File: doc/BRIEF.md
# Multi-width shift and rotate unit

This unit is the accumulator shift and rotate engine of a small processor core. The core hands it an operation code, an operand size, a 32-bit accumulator value, the current carry flag and an 8-bit shift count taken from a count register. The unit runs the operation and returns the shifted value, the new carry and the zero and negative flags of the result.

There are three groups of operations. Byte rotates pass through the carry flag. Word shifts move the value by one bit. Multi-bit shifts move the value by the count, at byte, word or long size. The multi-bit shifts move one bit position per clock after a fixed setup period, so their latency depends on the count.

The request side is a valid/ready stream. A request is taken in the cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time an operation is in flight, and requests offered then are dropped, not held. The result side cannot be back-pressured. `out_valid` is high for exactly one cycle, and the consumer must capture `out_data` and the flags in that cycle.

Top module: `shrot_unit`

## Requirements
- R1: After reset `busy` is 0, `in_ready` is 1 and `out_valid` is 0.
- R2: Opcodes 0 (rotate right) and 1 (rotate left) act on the low byte and always use byte size. Carry and the 8 bits form a 9-bit ring that moves by one position. The result appears 3 cycles after the request is accepted.
- R3: Opcodes 2 (arithmetic right), 3 (logical right) and 4 (logical left) shift the low 16 bits by one bit and always use word size. The result appears 2 cycles after acceptance.
- R4: Opcodes 5 (arithmetic right), 6 (logical right) and 7 (logical left) shift by `in_count` bit positions. The size field `in_size` selects the width: 0 is byte (8), 1 is word (16), 2 or 3 is long (32).
- R5: A count shift with count 0 finishes 6 cycles after acceptance. Any other count finishes 5 + count cycles after acceptance. Acceptance is the clock edge that takes the request; cycle N is the cycle after the N-th edge counted from that one.
- R6: Carry-out is the last bit shifted out. With count 0 the carry-out equals the carry-in and the operand is unchanged.
- R7: An arithmetic right shift fills with the sign bit of the selected size. Bits of `out_data` above the selected size are 0.
- R8: `out_zero` is 1 when the result at the selected size is 0. `out_neg` is the top bit of the result at that size.
- R9: `busy` is high from the cycle after acceptance through the result cycle, inclusive. `out_valid` is high only in that last busy cycle, and the result outputs are valid there.
- R10: A request offered while `busy` is high is ignored. It does not change the result of the operation in flight and produces no result of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can take a request (idle) |
| in_op | input | 3 | Operation code, see R2 to R4 |
| in_size | input | 2 | Operand size for count shifts |
| in_data | input | 32 | Accumulator operand |
| in_carry | input | 1 | Carry flag in |
| in_count | input | 8 | Unsigned shift count |
| busy | output | 1 | Operation in flight |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 32 | Result, zero above the size |
| out_carry | output | 1 | Carry flag out |
| out_zero | output | 1 | Result is zero at its size |
| out_neg | output | 1 | Top bit of result at its size |

## Verification
The embedded assertions check the timing shape on every cycle. They cover busy staying high until the result strobe, the strobe lasting one cycle and ending busy, and the fixed 3-cycle and 2-cycle latencies of rotates and single shifts. They also check that result bits above the size stay zero and that requests offered while busy leave the captured operation untouched. The arithmetic content can only be shown by the scoreboard scenarios. That content covers the rotate ring through carry, sign fill at each size, count-dependent latency including count 0 and counts larger than the width, the final carry, and the zero and negative flags.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int unsigned ACC_W = 32;

  typedef enum logic [2:0] {
    OP_RORC = 3'd0,
    OP_ROLC = 3'd1,
    OP_ASR1 = 3'd2,
    OP_LSR1 = 3'd3,
    OP_SHL1 = 3'd4,
    OP_ASRN = 3'd5,
    OP_LSRN = 3'd6,
    OP_SHLN = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONGX = 2'd3
  } size_e;

  function automatic logic op_is_rot(op_e op);
    return (op == OP_RORC) || (op == OP_ROLC);
  endfunction

  function automatic logic op_is_multi(op_e op);
    return (op == OP_ASRN) || (op == OP_LSRN) || (op == OP_SHLN);
  endfunction

  function automatic logic op_is_right(op_e op);
    return (op == OP_RORC) || (op == OP_ASR1) || (op == OP_LSR1) ||
           (op == OP_ASRN) || (op == OP_LSRN);
  endfunction

  function automatic logic op_is_arith(op_e op);
    return (op == OP_ASR1) || (op == OP_ASRN);
  endfunction

  function automatic size_e eff_size(op_e op, size_e sz);
    if (op_is_rot(op))          return SZ_BYTE;
    else if (!op_is_multi(op))  return SZ_WORD;
    else if (sz == SZ_LONGX)    return SZ_LONG;
    else                        return sz;
  endfunction

  function automatic logic [ACC_W-1:0] size_mask(size_e sz);
    case (sz)
      SZ_BYTE: return ACC_W'(32'h0000_00FF);
      SZ_WORD: return ACC_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [4:0] size_msb(size_e sz);
    case (sz)
      SZ_BYTE: return 5'd7;
      SZ_WORD: return 5'd15;
      default: return 5'(ACC_W - 1);
    endcase
  endfunction

endpackage

// File: rtl/shrot_seq.sv
module shrot_seq
  import shrot_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SETUP_CYC = 5,
  parameter int ROT_CYC   = 3,
  parameter int SGL_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  op_e              op,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             last,
  output logic             step_en
);

  localparam int LEFT_W = $clog2(SETUP_CYC + (1 << CNT_W) + 1);

  logic [LEFT_W-1:0] left_q, left_init;
  logic [CNT_W-1:0]  nshift_q, nshift_init;
  logic              busy_q;

  always_comb begin
    if (op_is_multi(op)) begin
      nshift_init = count;
      if (count == '0) left_init = LEFT_W'(SETUP_CYC);
      else             left_init = LEFT_W'(SETUP_CYC - 1) + LEFT_W'(count);
    end else if (op_is_rot(op)) begin
      nshift_init = CNT_W'(1);
      left_init   = LEFT_W'(ROT_CYC - 1);
    end else begin
      nshift_init = CNT_W'(1);
      left_init   = LEFT_W'(SGL_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      left_q   <= '0;
      nshift_q <= '0;
    end else if (accept && !busy_q) begin
      busy_q   <= 1'b1;
      left_q   <= left_init;
      nshift_q <= nshift_init;
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - LEFT_W'(1);
    end
  end

  assign busy    = busy_q;
  assign last    = busy_q && (left_q == '0);
  assign step_en = busy_q && (left_q != '0) && (left_q <= LEFT_W'(nshift_q));

  // R9: busy holds until the final cycle
  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  // R9: the final cycle ends the operation and is a single pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!busy && !last));

endmodule

// File: rtl/shrot_step.sv
module shrot_step
  import shrot_pkg::*;
(
  input  op_e              op,
  input  size_e            size,
  input  logic [ACC_W-1:0] acc,
  input  logic             cin,
  output logic [ACC_W-1:0] acc_nx,
  output logic             cout
);

  logic [ACC_W-1:0] mask;
  logic [4:0]       msb_idx;
  logic             msb;
  logic             fill;
  logic [ACC_W-1:0] shifted;

  always_comb begin
    mask    = size_mask(size);
    msb_idx = size_msb(size);
    msb     = acc[msb_idx];
    shifted = '0;
    fill    = 1'b0;
    if (op_is_right(op)) begin
      if (op == OP_RORC)       fill = cin;
      else if (op_is_arith(op)) fill = msb;
      cout             = acc[0];
      shifted          = acc >> 1;
      shifted[msb_idx] = fill;
    end else begin
      if (op == OP_ROLC) fill = cin;
      cout    = msb;
      shifted = (acc << 1) | ACC_W'(fill);
    end
    acc_nx = shifted & mask;
  end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
(
  input  size_e            size,
  input  logic [ACC_W-1:0] res,
  output logic             zero,
  output logic             neg
);

  always_comb begin
    zero = (res & size_mask(size)) == '0;
    neg  = res[size_msb(size)];
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SETUP_CYC = 5,
  parameter int ROT_CYC   = 3,
  parameter int SGL_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [1:0]       in_size,
  input  logic [31:0]      in_data,
  input  logic             in_carry,
  input  logic [CNT_W-1:0] in_count,
  output logic             busy,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             out_carry,
  output logic             out_zero,
  output logic             out_neg
);

  op_e              op_in, op_q;
  size_e            size_in, size_q;
  logic [ACC_W-1:0] acc_q, acc_nx;
  logic             c_q, c_nx;
  logic             accept, last, step_en;

  assign op_in    = op_e'(in_op);
  assign size_in  = eff_size(op_in, size_e'(in_size));
  assign accept   = in_valid && !busy;
  assign in_ready = !busy;

  shrot_seq #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .ROT_CYC(ROT_CYC), .SGL_CYC(SGL_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op(op_in), .count(in_count),
    .busy(busy), .last(last), .step_en(step_en)
  );

  shrot_step u_step (
    .op(op_q), .size(size_q), .acc(acc_q), .cin(c_q),
    .acc_nx(acc_nx), .cout(c_nx)
  );

  shrot_flags u_flags (
    .size(size_q), .res(acc_q), .zero(out_zero), .neg(out_neg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_RORC;
      size_q <= SZ_BYTE;
      acc_q  <= '0;
      c_q    <= 1'b0;
    end else if (accept) begin
      op_q   <= op_in;
      size_q <= size_in;
      acc_q  <= in_data & size_mask(size_in);
      c_q    <= in_carry;
    end else if (step_en) begin
      acc_q  <= acc_nx;
      c_q    <= c_nx;
    end
  end

  assign out_valid = last;
  assign out_data  = acc_q;
  assign out_carry = c_q;

  // R7: nothing above the selected size reaches the result
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ~size_mask(size_q)) == '0));
  // R10: a request while busy leaves the captured operation alone
  a_r10_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !out_valid) |=> ($stable(op_q) && $stable(size_q) && busy));
  // R2: rotate through carry finishes in the third cycle
  a_r2_rot_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op <= 3'd1)) |=> !out_valid ##1 !out_valid ##1 out_valid);
  // R3: single-bit word shifts finish in the second cycle
  a_r3_single_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op >= 3'd2) && (in_op <= 3'd4)) |=> !out_valid ##1 out_valid);
  // R1: strobe never without busy
  a_r1_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] d;
    logic        c;
    logic        z;
    logic        n;
    int          lat;
    int          t0;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_data = '0;
  logic        in_carry = 1'b0;
  logic [7:0]  in_count = '0;
  logic        busy, out_valid, out_carry, out_zero, out_neg;
  logic [31:0] out_data;

  int   n_checks = 0;
  int   n_errors = 0;
  int   cyc = 0;
  int   spurious = 0;
  bit   finished = 0;
  exp_t sb[$];

  shrot_unit u_shrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_data(in_data), .in_carry(in_carry),
    .in_count(in_count), .busy(busy), .out_valid(out_valid), .out_data(out_data),
    .out_carry(out_carry), .out_zero(out_zero), .out_neg(out_neg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [1:0] sz,
                                 input logic [31:0] d, input logic ci, input logic [7:0] cnt);
    exp_t e;
    int w;
    int steps;
    logic [31:0] m;
    logic [31:0] a;
    logic c;
    logic fill;
    if (op <= 3'd1)      w = 8;
    else if (op <= 3'd4) w = 16;
    else                 w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    a = d & m;
    c = ci;
    steps = (op <= 3'd4) ? 1 : int'(cnt);
    for (int i = 0; i < steps; i++) begin
      if (op == 3'd0 || op == 3'd2 || op == 3'd3 || op == 3'd5 || op == 3'd6) begin
        fill = (op == 3'd0) ? c : ((op == 3'd2 || op == 3'd5) ? a[w-1] : 1'b0);
        c = a[0];
        a = a >> 1;
        a[w-1] = fill;
      end else begin
        fill = (op == 3'd1) ? c : 1'b0;
        c = a[w-1];
        a = ((a << 1) | {31'd0, fill}) & m;
      end
    end
    e.d = a;
    e.c = c;
    e.z = (a == 32'd0);
    e.n = a[w-1];
    e.lat = (op <= 3'd1) ? 3 : (op <= 3'd4) ? 2 : ((cnt == 8'd0) ? 6 : 5 + int'(cnt));
    e.t0 = 0;
    e.tag = "";
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] d,
                       input logic ci, input logic [7:0] cnt, input string tag);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_op = op; in_size = sz; in_data = d; in_carry = ci; in_count = cnt;
    in_valid = 1'b1;
    e = model(op, sz, d, ci, cnt);
    e.t0 = cyc;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compare each result strobe against the scoreboard head
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          spurious++;
        end else begin
          e = sb.pop_front();
          chk(out_data == e.d, {e.tag, " data"}, out_data, e.d);
          chk(out_carry == e.c, {e.tag, " R6 carry"}, out_carry, e.c);
          chk(out_zero == e.z, {e.tag, " R8 zero"}, out_zero, e.z);
          chk(out_neg == e.n, {e.tag, " R8 neg"}, out_neg, e.n);
          chk((cyc - e.t0) == e.lat, {e.tag, " R5 latency"}, cyc - e.t0, e.lat);
          chk(busy == 1'b1, {e.tag, " R9 busy at strobe"}, busy, 1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    rst_n = 1'b1;

    // R2: rotate through carry, byte
    drive(3'd0, 2'd2, 32'h0000_0081, 1'b0, 8'd9, "R2 rorc");
    drive(3'd0, 2'd1, 32'h1234_5600, 1'b1, 8'd0, "R2 rorc cin");
    drive(3'd1, 2'd0, 32'h0000_0080, 1'b0, 8'd3, "R2 rolc");
    drive(3'd1, 2'd2, 32'hFFFF_FF41, 1'b1, 8'd0, "R2 rolc upper");
    // R3: single-bit word shifts
    drive(3'd2, 2'd0, 32'hABCD_8002, 1'b0, 8'd7, "R3 asr1");
    drive(3'd3, 2'd2, 32'h0000_8003, 1'b0, 8'd0, "R3 lsr1");
    drive(3'd4, 2'd0, 32'h0000_C000, 1'b0, 8'd0, "R3 shl1");
    // R4 R7: count shifts at each size
    drive(3'd5, 2'd0, 32'hFFFF_FF90, 1'b0, 8'd3, "R4 R7 asrn byte");
    drive(3'd5, 2'd1, 32'h0000_8421, 1'b0, 8'd4, "R4 R7 asrn word");
    drive(3'd5, 2'd2, 32'h8000_0001, 1'b1, 8'd200, "R4 R7 asrn long big");
    drive(3'd6, 2'd3, 32'hF000_000F, 1'b0, 8'd40, "R4 lsrn long past width");
    drive(3'd6, 2'd1, 32'h0001_8001, 1'b1, 8'd1, "R4 lsrn word");
    drive(3'd7, 2'd2, 32'h0000_0003, 1'b0, 8'd31, "R4 shln long");
    drive(3'd7, 2'd0, 32'h0000_00FF, 1'b0, 8'd8, "R4 shln byte full");
    // R6: count zero keeps operand and carry
    drive(3'd7, 2'd1, 32'hFFFF_8001, 1'b1, 8'd0, "R6 zero count");
    drive(3'd6, 2'd0, 32'h0000_0055, 1'b0, 8'd0, "R6 zero count b");

    // R10: requests while busy are ignored
    drive(3'd6, 2'd2, 32'h8765_4321, 1'b0, 8'd20, "R10 inflight");
    for (int k = 0; k < 6; k++) begin
      chk(in_ready == 1'b0, "R10 in_ready low while busy", in_ready, 0);
      in_op = 3'd4; in_size = 2'd0; in_data = 32'h0000_FFFF; in_carry = 1'b1; in_count = 8'd1;
      in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;

    while (sb.size() != 0 || busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(spurious == 0, "R10 no extra result", spurious, 0);
    chk(out_valid == 1'b0 && busy == 1'b0, "R9 idle after done", busy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule